// File: doc/BRIEF.md
# Dual-mode partitioned mantissa multiplier

This block is a pipelined unsigned multiplier for the significand path of a floating-point unit. It has four half-width sub-multipliers. A mode bit decides how their inputs are steered and how their outputs are used. In wide mode the sub-multipliers form the four cross products of one pair of full-width operands, and an adder stage merges them into one double-width product. In packed mode each sub-multiplier serves its own lane, and the four products come out side by side.

The mode bit is captured with the operands and travels down the pipeline beside them. Modes can therefore change from one cycle to the next while a new operation is accepted every cycle. Both modes have the same two-cycle latency. Exponents, rounding, normalization and special values are handled outside the block.

With the half-lane width H (default 28):
- each operand bus is 4H bits wide;
- the result bus is 8H bits wide;
- a wide operand is the low 2H bits of its bus.

Top module: `dual_mode_mul`

## Requirements
- R1: While `rst_ni` is low, and immediately after it is released, `valid_o` is 0 and `result_o` is all zeros.
- R2: `valid_o` is 1 exactly two rising clock edges after `valid_i` was 1, and 0 otherwise. An operation can be accepted on every cycle.
- R3: In wide mode (`wide_mode_i` = 1), `result_o[4H-1:0]` equals `a_i[2H-1:0]` times `b_i[2H-1:0]`, as unsigned numbers.
- R4: In wide mode, `result_o[8H-1:4H]` is zero.
- R5: In wide mode, the operand bits `a_i[4H-1:2H]` and `b_i[4H-1:2H]` have no effect on the result.
- R6: In packed mode (`wide_mode_i` = 0), for each lane k from 0 to 3, `result_o[2H*k+2H-1:2H*k]` equals `a_i[H*k+H-1:H*k]` times `b_i[H*k+H-1:H*k]`, as unsigned numbers.
- R7: The mode bit is sampled on the same edge as the operands. Back-to-back operations of different modes each give the result of their own mode.
- R8: When no result is due on a cycle, `result_o` keeps the value of the last delivered result.
- R9: All-ones operands give the largest product without overflow:
  - wide mode gives (2^2H-1)^2;
  - packed mode gives (2^H-1)^2 in every lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and mode are valid this cycle |
| wide_mode_i | input | 1 | 1: one wide product; 0: four packed lane products |
| a_i | input | 4H | Multiplicand bus (wide operand in low 2H bits) |
| b_i | input | 4H | Multiplier bus (wide operand in low 2H bits) |
| valid_o | output | 1 | Result valid, two cycles after valid_i |
| result_o | output | 8H | Wide product in the low 4H bits, or four 2H-bit lane products |

## Verification
The bench builds the block with H = 4. This makes the wide operands 8 bits each, so every one of the 65,536 wide operand pairs is applied, with random values in the ignored upper operand bits. Lane 0 of packed mode is swept over all 256 pairs while the other lanes take random values. All-ones operands are applied in both modes. A long random stream then switches modes cycle by cycle and leaves random idle gaps, which exercises the mode pipeline, the valid timing and the hold behaviour.

// File: rtl/mm_pkg.sv
package mm_pkg;
  localparam int unsigned N_SUB = 4;

  typedef enum logic {
    MODE_PACKED = 1'b0,
    MODE_WIDE   = 1'b1
  } mode_e;
endpackage

// File: rtl/mm_opsel.sv
// Steers operand slices into the four sub-multipliers.
// Wide mapping: sub0 = alo*blo, sub1 = ahi*blo, sub2 = alo*bhi, sub3 = ahi*bhi.
module mm_opsel
  import mm_pkg::*;
#(
  parameter int unsigned HALF_W = 28,
  localparam int unsigned OP_W = N_SUB * HALF_W
) (
  input  logic                          wide_i,
  input  logic [OP_W-1:0]               a_i,
  input  logic [OP_W-1:0]               b_i,
  output logic [N_SUB-1:0][HALF_W-1:0]  x_o,
  output logic [N_SUB-1:0][HALF_W-1:0]  y_o
);
  for (genvar k = 0; k < N_SUB; k++) begin : g_sel
    localparam int unsigned XW = k % 2;
    localparam int unsigned YW = k / 2;

    assign x_o[k] = wide_i ? a_i[XW*HALF_W +: HALF_W] : a_i[k*HALF_W +: HALF_W];
    assign y_o[k] = wide_i ? b_i[YW*HALF_W +: HALF_W] : b_i[k*HALF_W +: HALF_W];
  end
endmodule

// File: rtl/mm_submul.sv
// Registered half-width unsigned multiplier (pipeline stage 1).
module mm_submul #(
  parameter int unsigned HALF_W = 28,
  localparam int unsigned PROD_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              en_i,
  input  logic [HALF_W-1:0] x_i,
  input  logic [HALF_W-1:0] y_i,
  output logic [PROD_W-1:0] p_o
);
  always_ff @(posedge clk_i) begin
    if (en_i) p_o <= PROD_W'(x_i) * PROD_W'(y_i);
  end
endmodule

// File: rtl/mm_combine.sv
// Merges the four cross products into one double-width sum.
module mm_combine
  import mm_pkg::*;
#(
  parameter int unsigned HALF_W = 28,
  localparam int unsigned PROD_W = 2 * HALF_W,
  localparam int unsigned WIDE_W = 2 * PROD_W
) (
  input  logic [N_SUB-1:0][PROD_W-1:0] p_i,
  output logic [WIDE_W-1:0]            sum_o
);
  logic [PROD_W:0] mid_sum;

  // Pre-add the two cross terms, which carry the same weight.
  assign mid_sum = {1'b0, p_i[1]} + {1'b0, p_i[2]};
  assign sum_o   = WIDE_W'(p_i[0])
                 + (WIDE_W'(mid_sum) << HALF_W)
                 + (WIDE_W'(p_i[3]) << PROD_W);
endmodule

// File: rtl/dual_mode_mul.sv
module dual_mode_mul
  import mm_pkg::*;
#(
  parameter int unsigned HALF_W = 28,
  localparam int unsigned OP_W   = N_SUB * HALF_W,
  localparam int unsigned PROD_W = 2 * HALF_W,
  localparam int unsigned WIDE_W = 2 * PROD_W,
  localparam int unsigned RES_W  = N_SUB * PROD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             wide_mode_i,
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  output logic             valid_o,
  output logic [RES_W-1:0] result_o
);
  logic [N_SUB-1:0][HALF_W-1:0] sub_x;
  logic [N_SUB-1:0][HALF_W-1:0] sub_y;
  logic [N_SUB-1:0][PROD_W-1:0] sub_p;
  logic [WIDE_W-1:0]            wide_sum;
  logic                         s1_valid;
  mode_e                        s1_mode;
  mode_e                        s2_mode;

  mm_opsel #(.HALF_W(HALF_W)) u_opsel (
    .wide_i (wide_mode_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .x_o    (sub_x),
    .y_o    (sub_y)
  );

  for (genvar k = 0; k < N_SUB; k++) begin : g_sub
    mm_submul #(.HALF_W(HALF_W)) u_sub (
      .clk_i (clk_i),
      .en_i  (valid_i),
      .x_i   (sub_x[k]),
      .y_i   (sub_y[k]),
      .p_o   (sub_p[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_mode  <= MODE_PACKED;
    end else begin
      s1_valid <= valid_i;
      if (valid_i) s1_mode <= mode_e'(wide_mode_i);
    end
  end

  mm_combine #(.HALF_W(HALF_W)) u_comb (
    .p_i   (sub_p),
    .sum_o (wide_sum)
  );

  // Stage 2: wide sum or lane products; held while idle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      s2_mode  <= MODE_PACKED;
      result_o <= '0;
    end else begin
      valid_o <= s1_valid;
      if (s1_valid) begin
        s2_mode  <= s1_mode;
        result_o <= (s1_mode == MODE_WIDE) ? RES_W'(wide_sum) : sub_p;
      end
    end
  end

  assert_valid_lat_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##2 valid_o);

  assert_idle_lat_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ##2 !valid_o);

  assert_mode_follows_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##2 (s2_mode == mode_e'($past(wide_mode_i, 2))));

  assert_wide_upper_zero_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && s2_mode == MODE_WIDE) |-> (result_o[RES_W-1:WIDE_W] == '0));

  assert_wide_low_bits_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && s2_mode == MODE_WIDE) |-> (result_o[HALF_W-1:0] == $past(sub_p[0][HALF_W-1:0])));

  assert_hold_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(s1_valid) |-> $stable(result_o));
endmodule

// File: tb/dual_mode_mul_test.sv
`timescale 1ns/1ps
module dual_mode_mul_test;
  localparam int unsigned H  = 4;
  localparam int unsigned OW = 4 * H;
  localparam int unsigned RW = 8 * H;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic          wide_i = 1'b0;
  logic [OW-1:0] a_i = '0;
  logic [OW-1:0] b_i = '0;
  logic          valid_o;
  logic [RW-1:0] result_o;

  int n_checks = 0;
  int n_fail = 0;

  logic          pv [2];
  logic [RW-1:0] pr [2];
  string         pt [2];
  logic [RW-1:0] last_res;

  always #2 clk = ~clk;

  dual_mode_mul #(.HALF_W(H)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .valid_i     (valid_i),
    .wide_mode_i (wide_i),
    .a_i         (a_i),
    .b_i         (b_i),
    .valid_o     (valid_o),
    .result_o    (result_o)
  );

  function automatic logic [RW-1:0] model(bit w, logic [OW-1:0] a, logic [OW-1:0] b);
    logic [RW-1:0] r;
    r = '0;
    if (w) begin
      r = RW'(a[2*H-1:0]) * RW'(b[2*H-1:0]);
    end else begin
      for (int k = 0; k < 4; k++)
        r[k*2*H +: 2*H] = (2*H)'(a[k*H +: H]) * (2*H)'(b[k*H +: H]);
    end
    return r;
  endfunction

  task automatic check(string tag, logic [RW-1:0] act, logic [RW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(bit v, bit w, logic [OW-1:0] a, logic [OW-1:0] b, string tag);
    @(negedge clk);
    check("R2 valid", RW'(valid_o), RW'(pv[1]));
    if (pv[1]) begin
      check(pt[1], result_o, pr[1]);
      last_res = pr[1];
    end else begin
      check("R8 hold", result_o, last_res);
    end
    pv[1] = pv[0]; pr[1] = pr[0]; pt[1] = pt[0];
    pv[0] = v; pr[0] = model(w, a, b); pt[0] = tag;
    valid_i = v; wide_i = w; a_i = a; b_i = b;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    pv[0] = 1'b0; pv[1] = 1'b0; pr[0] = '0; pr[1] = '0; pt[0] = ""; pt[1] = "";
    last_res = '0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", RW'(valid_o), '0);
    check("R1 reset result", result_o, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 after release valid", RW'(valid_o), '0);
    check("R1 after release result", result_o, '0);

    // Exhaustive wide sweep, upper operand bits random.
    for (int i = 0; i < 65536; i++) begin
      logic [OW-1:0] a, b;
      a = {OW'($urandom)} & ~OW'((1 << (2*H)) - 1);
      b = {OW'($urandom)} & ~OW'((1 << (2*H)) - 1);
      a[2*H-1:0] = (2*H)'(i >> (2*H));
      b[2*H-1:0] = (2*H)'(i);
      issue(1'b1, 1'b1, a, b, "R3 R4 R5 wide");
    end

    // Packed: lane 0 exhaustive, other lanes random.
    for (int i = 0; i < 256; i++) begin
      logic [OW-1:0] a, b;
      a = OW'($urandom); b = OW'($urandom);
      a[H-1:0] = H'(i >> H);
      b[H-1:0] = H'(i);
      issue(1'b1, 1'b0, a, b, "R6 packed");
    end

    // All-ones in both modes.
    issue(1'b1, 1'b1, '1, '1, "R9 wide all-ones");
    issue(1'b1, 1'b0, '1, '1, "R9 packed all-ones");
    issue(1'b1, 1'b1, '1, '1, "R9 wide all-ones");
    issue(1'b1, 1'b0, '1, '1, "R9 packed all-ones");

    // Mode changes every cycle, back to back.
    for (int i = 0; i < 1000; i++)
      issue(1'b1, i[0], OW'($urandom), OW'($urandom), "R7 alternating");

    // Random modes with idle gaps.
    for (int i = 0; i < 3000; i++) begin
      bit v;
      v = ($urandom % 3) != 0;
      issue(v, 1'($urandom), OW'($urandom), OW'($urandom), "R7 R2 random");
    end

    issue(1'b0, 1'b0, '0, '0, "drain");
    issue(1'b0, 1'b0, '0, '0, "drain");
    issue(1'b0, 1'b0, '0, '0, "drain");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule